// File: doc/BRIEF.md
# Real-Time-Clock Second Prescaler with Digital Rate Trim

This block turns a free-running watch-crystal clock into a single-cycle pulse once per second, ready to feed a calendar counter. The crystal's rate error is corrected by a signed trim code held in a small register. The block does not change the crystal frequency. Over a fixed window of seconds it lengthens or shortens individual seconds by a few oscillator counts, so the average second comes out right while no single second drifts far from nominal.

A 6-bit trim code uses bit 5 as the direction and bits 4:0 as the size. A cleared direction bit slows time by one count per window for each magnitude step, which is about 2.03 ppm at 32768 Hz over 15 s. A set direction bit speeds time by two counts per window for each step, about 4.07 ppm. The available range is roughly -63 ppm to +126 ppm. The same write port also holds two output-control bits that drive an open-drain pin. One bit selects a static level. The other bit overrides that level with a square wave divided straight from the oscillator, which lets the raw crystal rate be measured before a trim code is chosen.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: `tick1Hz` is high for exactly one oscillator cycle per second. With a trim magnitude of 0, every second lasts exactly CLK_HZ cycles. The first tick after reset release comes on the CLK_HZ-th rising edge, counting the first edge after release as edge 1.
- R2: Trim code layout is bit 5 = direction and bits 4:0 = magnitude N. With direction 0, a window of WINDOW_SECS seconds lasts CLK_HZ*WINDOW_SECS + N cycles. With direction 1, it lasts CLK_HZ*WINDOW_SECS - 2N cycles. N = 0 gives the nominal length for either direction.
- R3: Let M be the per-window count adjustment (N or 2N). Second s of a window (s = 0 to WINDOW_SECS-1) is adjusted by floor(M/WINDOW_SECS), plus one more count when s < M mod WINDOW_SECS. The second is longer for direction 0 and shorter for direction 1.
- R4: No second differs from CLK_HZ by more than ceil(62/WINDOW_SECS) cycles.
- R5: A trim write takes effect at the first second of the next window and never inside the current one. Reset restarts the window at second 0.
- R6: After reset the trim code is 0, the frequency-test bit is 0 and the static-level bit is 1, so `pinDriveLow` is 0.
- R7: While the frequency-test bit is 1, the pin level is a square wave of period CAL_DIV cycles, whatever the static-level bit holds. The wave is low for the first CAL_DIV/2 cycles after reset release, is not affected by trim, and runs freely from reset.
- R8: While the frequency-test bit is 0, the pin level equals the static-level bit.
- R9: The pin is open drain. `pinDriveLow` = 1 pulls it low, and 0 releases it so that it reads high. Register writes use `cfgAddr` 0 for the trim code (`cfgWrData[5:0]`) and `cfgAddr` 1 for the controls: bit 0 is the static level and bit 1 is frequency-test. A write takes effect on the rising edge that samples `cfgWrEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oscClk | input | 1 | Crystal oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 1 | 0 = trim code, 1 = output controls |
| cfgWrData | input | TRIM_W | Write data |
| tick1Hz | output | 1 | One-cycle pulse at the end of each second |
| pinDriveLow | output | 1 | 1 pulls the open-drain pin low, 0 releases it |

## Verification
The assertions assume that the magnitude field is never large enough to shorten a second to zero counts, and that CLK_HZ is large compared with the worst per-second adjustment. Under those conditions a second always lasts more than one cycle and the internal counter never wraps. The bench uses a reduced configuration (128 Hz, 15-second window, divide-by-8 test wave) where the worst case is 5 counts against 128, so every one of the 64 trim codes can be applied in turn. Each write is placed just after a window boundary, which keeps every window under a single known code.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
  localparam int ADJ_W = 8;

  // Per-second stretch request from control to datapath
  typedef struct packed {
    logic             lengthen;
    logic             shorten;
    logic [ADJ_W-1:0] amount;
  } adjStrobes_t;
endpackage

// File: rtl/rtc_trim_ctrl.sv
module rtc_trim_ctrl
  import rtc_trim_pkg::*;
#(
  parameter int WINDOW_SECS = 15,
  parameter int TRIM_W      = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [TRIM_W-1:0] wrData,
  input  logic              secDone,
  output adjStrobes_t       adj,
  output logic              outSel,
  output logic              ftEn
);
  localparam int SEC_W   = $clog2(WINDOW_SECS + 1);
  localparam int CALC_W  = TRIM_W + SEC_W;
  localparam int MAG_MAX = 2 ** (TRIM_W - 1) - 1;
  localparam logic [CALC_W-1:0] WIN_C = CALC_W'(WINDOW_SECS);
  localparam logic [CALC_W-1:0] K_MAX = CALC_W'((2 * MAG_MAX + WINDOW_SECS - 1) / WINDOW_SECS);
  localparam logic [SEC_W-1:0]  LAST_SEC = SEC_W'(WINDOW_SECS - 1);

  logic [TRIM_W-1:0] trimReg;
  logic              actSign;
  logic [CALC_W-1:0] actBase;
  logic [SEC_W-1:0]  actRem;
  logic [SEC_W-1:0]  secIdx;

  logic [TRIM_W-2:0] trimMag;
  logic [CALC_W-1:0] totalAdj, nextBase, nextRem, kNow;
  logic              winEnd;

  always_comb begin
    trimMag  = trimReg[TRIM_W-2:0];
    totalAdj = trimReg[TRIM_W-1] ? (CALC_W'(trimMag) << 1) : CALC_W'(trimMag);
    nextBase = totalAdj / WIN_C;
    nextRem  = totalAdj % WIN_C;
    winEnd   = secDone && (secIdx == LAST_SEC);
    kNow     = actBase + CALC_W'(secIdx < actRem);
    adj.amount   = ADJ_W'(kNow);
    adj.lengthen = !actSign && (kNow != '0);
    adj.shorten  = actSign && (kNow != '0);
  end

  // Register write port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trimReg <= '0;
      outSel  <= 1'b1;
      ftEn    <= 1'b0;
    end else if (wrEn) begin
      if (wrAddr) begin
        outSel <= wrData[0];
        ftEn   <= wrData[1];
      end else begin
        trimReg <= wrData;
      end
    end
  end

  // Second index within the window; trim latched at window end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secIdx  <= '0;
      actSign <= 1'b0;
      actBase <= '0;
      actRem  <= '0;
    end else if (secDone) begin
      if (winEnd) begin
        secIdx  <= '0;
        actSign <= trimReg[TRIM_W-1];
        actBase <= nextBase;
        actRem  <= SEC_W'(nextRem);
      end else begin
        secIdx <= secIdx + 1'b1;
      end
    end
  end

  a_r4_adj_bound: assert property (@(posedge clk) disable iff (!rstN)
    kNow <= K_MAX);

  a_r5_trim_hold: assert property (@(posedge clk) disable iff (!rstN)
    !winEnd |=> ($stable(actBase) && $stable(actRem) && $stable(actSign)));

  a_r3_sec_range: assert property (@(posedge clk) disable iff (!rstN)
    secIdx <= LAST_SEC);
endmodule

// File: rtl/rtc_trim_dpath.sv
module rtc_trim_dpath
  import rtc_trim_pkg::*;
#(
  parameter int CLK_HZ  = 32768,
  parameter int CAL_DIV = 64,
  parameter int CNT_W   = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  adjStrobes_t adj,
  input  logic        ftEn,
  input  logic        outSel,
  output logic        secDone,
  output logic        pinDriveLow
);
  localparam int CAL_W = $clog2(CAL_DIV);
  localparam logic [CNT_W-1:0] NOM_LAST = CNT_W'(CLK_HZ - 1);

  logic [CNT_W-1:0] cnt, amt, lastCount;
  logic [CAL_W-1:0] calCnt;
  logic             calWave, pinLevel;

  always_comb begin
    amt = CNT_W'(adj.amount);
    if (adj.lengthen)     lastCount = NOM_LAST + amt;
    else if (adj.shorten) lastCount = NOM_LAST - amt;
    else                  lastCount = NOM_LAST;
    secDone = (cnt == lastCount);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cnt <= '0;
    else if (secDone) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  // Untrimmed divider for the test wave
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) calCnt <= '0;
    else       calCnt <= calCnt + 1'b1;
  end

  always_comb begin
    calWave     = calCnt[CAL_W-1];
    pinLevel    = ftEn ? calWave : outSel;
    pinDriveLow = !pinLevel;
  end

  a_r1_tick_single: assert property (@(posedge clk) disable iff (!rstN)
    secDone |=> !secDone);

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= lastCount);
endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
  import rtc_trim_pkg::*;
#(
  parameter int CLK_HZ      = 32768,
  parameter int WINDOW_SECS = 15,
  parameter int TRIM_W      = 6,
  parameter int CAL_DIV     = 64
) (
  input  logic              oscClk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgAddr,
  input  logic [TRIM_W-1:0] cfgWrData,
  output logic              tick1Hz,
  output logic              pinDriveLow
);
  localparam int MAG_MAX = 2 ** (TRIM_W - 1) - 1;
  localparam int K_MAX   = (2 * MAG_MAX + WINDOW_SECS - 1) / WINDOW_SECS;
  localparam int CNT_W   = $clog2(CLK_HZ + K_MAX + 1);

  adjStrobes_t adj;
  logic        secDone, outSel, ftEn;

  rtc_trim_ctrl #(
    .WINDOW_SECS(WINDOW_SECS),
    .TRIM_W     (TRIM_W)
  ) u_ctrl (
    .clk    (oscClk),
    .rstN   (rstN),
    .wrEn   (cfgWrEn),
    .wrAddr (cfgAddr),
    .wrData (cfgWrData),
    .secDone(secDone),
    .adj    (adj),
    .outSel (outSel),
    .ftEn   (ftEn)
  );

  rtc_trim_dpath #(
    .CLK_HZ (CLK_HZ),
    .CAL_DIV(CAL_DIV),
    .CNT_W  (CNT_W)
  ) u_dpath (
    .clk        (oscClk),
    .rstN       (rstN),
    .adj        (adj),
    .ftEn       (ftEn),
    .outSel     (outSel),
    .secDone    (secDone),
    .pinDriveLow(pinDriveLow)
  );

  assign tick1Hz = secDone;
endmodule

// File: tb/rtc_trim_prescaler_bench.sv
module rtc_trim_prescaler_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BHZ  = 128;
  localparam int BWIN = 15;
  localparam int BCAL = 8;
  localparam int KMAX = (62 + BWIN - 1) / BWIN;
  localparam int WDOG = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic       cfgAddr = 1'b0;
  logic [5:0] cfgWrData = '0;
  logic       tick1Hz, pinDriveLow;

  int checks = 0;
  int errors = 0;
  int pos = 0;
  int tickCount = 0;
  int lastTick = -1;
  int winSum = 0;
  int cycles = 0;
  int codeForWin [0:70];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_trim_prescaler #(
    .CLK_HZ(BHZ), .WINDOW_SECS(BWIN), .TRIM_W(6), .CAL_DIV(BCAL)
  ) u_rtc_trim_prescaler (
    .oscClk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .tick1Hz(tick1Hz), .pinDriveLow(pinDriveLow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int expPeriod(input int c, input int s);
    int sg, m, k;
    sg = (c >> 5) & 1;
    m  = sg ? 2 * (c & 31) : (c & 31);
    k  = m / BWIN + ((s < (m % BWIN)) ? 1 : 0);
    return sg ? BHZ - k : BHZ + k;
  endfunction

  function automatic int expWindow(input int c);
    int sg;
    sg = (c >> 5) & 1;
    return sg ? BHZ * BWIN - 2 * (c & 31) : BHZ * BWIN + (c & 31);
  endfunction

  always @(posedge clk) begin
    if (rstN) pos <= pos + 1;
    else      pos <= 0;
    cycles <= cycles + 1;
  end

  // Tick monitor: checks every second and every window
  always @(negedge clk) begin
    if (!rstN) begin
      tickCount = 0;
      lastTick  = -1;
      winSum    = 0;
    end else if (tick1Hz) begin
      int w, s, c, per;
      w = tickCount / BWIN;
      s = tickCount % BWIN;
      c = codeForWin[w];
      per = pos - lastTick;
      chk(per == expPeriod(c, s), (c & 31) == 0 ? "R1 period" : "R3 second length", per, expPeriod(c, s));
      chk(per >= BHZ - KMAX && per <= BHZ + KMAX, "R4 deviation", per, BHZ);
      winSum += per;
      if (s == BWIN - 1) begin
        chk(winSum == expWindow(c), "R2 window total", winSum, expWindow(c));
        winSum = 0;
      end
      lastTick = pos;
      tickCount++;
    end
  end

  always @(posedge clk) begin
    if (cycles > WDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, WDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic writeReg(input bit addr, input int data);
    @(negedge clk); #1;
    cfgWrEn = 1'b1; cfgAddr = addr; cfgWrData = 6'(data);
    @(negedge clk); #1;
    cfgWrEn = 1'b0;
  endtask

  initial begin
    for (int i = 0; i <= 70; i++) codeForWin[i] = 0;
    repeat (3) @(negedge clk);
    chk(pinDriveLow == 1'b0, "R6 pin released in reset", pinDriveLow, 0);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(tick1Hz == 1'b0, "R1 no tick after reset", tick1Hz, 0);
    chk(pinDriveLow == 1'b0, "R6 reset pin state", pinDriveLow, 0);

    // Sweep all 64 trim codes; the code written in window w rules window w+1 (R5)
    for (int w = 0; w < 64; w++) begin
      while (tickCount < BWIN * w) @(negedge clk);
      codeForWin[w + 1] = w;
      writeReg(1'b0, w);
    end
    while (tickCount < BWIN * 65) @(negedge clk);

    // Test wave overrides the static level (R7)
    for (int sel = 0; sel < 2; sel++) begin
      writeReg(1'b1, 2 | sel);
      for (int i = 0; i < 2 * BCAL; i++) begin
        int lvl;
        @(negedge clk);
        lvl = ((pos % BCAL) >= BCAL / 2) ? 1 : 0;
        chk(pinDriveLow == !lvl, "R7 test wave", !pinDriveLow, lvl);
      end
    end
    // Static level with test off (R8, R9)
    writeReg(1'b1, 1);
    @(negedge clk);
    chk(pinDriveLow == 1'b0, "R8 static high released R9", pinDriveLow, 0);
    writeReg(1'b1, 0);
    @(negedge clk);
    chk(pinDriveLow == 1'b1, "R8 static low driven R9", pinDriveLow, 1);

    // Reset mid-window restarts the window with trim 0 (R5, R6)
    repeat (40) @(negedge clk);
    #1 rstN = 1'b0;
    for (int i = 0; i <= 70; i++) codeForWin[i] = 0;
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(pinDriveLow == 1'b0, "R6 controls restored", pinDriveLow, 0);
    // Check the level right after release: the wave must start low (R7)
    writeReg(1'b1, 3);
    @(negedge clk);
    chk(pinDriveLow == (((pos % BCAL) >= BCAL / 2) ? 1'b0 : 1'b1), "R7 wave phase after reset",
        !pinDriveLow, ((pos % BCAL) >= BCAL / 2) ? 1 : 0);
    while (tickCount < 2 * BWIN) @(negedge clk);
    chk(tickCount == 2 * BWIN, "R5 restart count", tickCount, 2 * BWIN);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule